// File: doc/BRIEF.md
# TDM Bus Timing and Strobe Generator

This block takes a master clock and an active-low 8 kHz frame pulse and derives from them everything a strobed-data CODEC and a transcoder datapath need for timing. It divides the master clock into a bit clock that is aligned to the frame pulse. It counts bit cells and timeslots from the cell that follows each pulse. It decodes two 8-bit channel strobes, a PCM window and an ADPCM word window, and it produces the per-cell enables that tell the datapath when to launch an output bit and when to sample an input bit.

The block watches the frame pulse pin to work out which bus mode is in use. Pulses arriving at the exact frame spacing select the frame-pulse TDM bus mode. A pin that stays quiet, high or low, drops the block back to the strobe-driven serial mode, in which the generated strobes are held off. A select input moves the channel strobes between the first and second slot pairs, and it moves the ADPCM window between slots 2 and 3. A power-down input freezes the counters and quiets the outputs until the next frame pulse.

Top module: `tdm_strobe_gen`

## Requirements
- R1: In the cycle after a master-clock edge that samples `fp_ni` low following a high sample (a falling edge), `bit_o` and `slot_o` read 0. The internal count then advances by one every cycle: `bit_o` is (count/2) mod 8 and `slot_o` is count/16.
- R2: Each bit cell lasts two master-clock cycles. In the first cycle `launch_o`=1, `sample_o`=0 and `bclk_o`=0. In the second cycle `launch_o`=0, `sample_o`=1 and `bclk_o`=1.
- R3: A frame holds 32 slots of 8 cells each, which is 512 cycles. Without a new pulse the count wraps from slot 31, bit 7 back to 0. In TDM mode, `frame_o` is 1 exactly in count 0.
- R4: `tdm_mode_o` rises in the cycle after a falling edge that arrives exactly 512 cycles after the previous falling edge.
- R5: A falling edge at any other spacing still realigns the counters (R1) but leaves `tdm_mode_o` unchanged, whether the block is in serial or TDM mode.
- R6: `tdm_mode_o` returns to 0 in the cycle after 1024 consecutive clock edges without a falling edge.
- R7: Once `fp_ni` has been sampled low on two consecutive edges, `bclk_o` is a steady 0 for as long as the pin stays low.
- R8: With `fp_ni` held high, `bclk_o` keeps toggling every cycle.
- R9: In TDM mode, with `sel_i`=0, `en1_o` is 1 during slot 0 and `en2_o` is 1 during slot 1. With `sel_i`=1 they cover slots 2 and 3. `pcm_win_o` is `en1_o` OR `en2_o`. In serial mode the strobes, the windows and `frame_o` are 0.
- R10: In TDM mode, `adpcm_win_o` is 1 during slot 2 when `sel_i`=0 and during slot 3 when `sel_i`=1. It is never 1 in slot 0 or slot 1.
- R11: While `pd_ni`=0, every generated output (bit clock, strobes, windows, enables, `frame_o`) is 0 and the counters hold their value. After `pd_ni` returns to 1, the outputs stay 0 and the counters stay frozen until the next falling edge, after which R1 applies.
- R12: After reset, `tdm_mode_o`=0, `bit_o`=0, `slot_o`=0, and the counters run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_ni | input | 1 | Frame pulse pin, active low |
| pd_ni | input | 1 | Power-down, active low |
| sel_i | input | 1 | Slot-pair select |
| bclk_o | output | 1 | Bit clock, half the master rate |
| en1_o | output | 1 | First channel strobe |
| en2_o | output | 1 | Second channel strobe |
| pcm_win_o | output | 1 | PCM timeslot window |
| adpcm_win_o | output | 1 | ADPCM word window |
| frame_o | output | 1 | Frame start pulse |
| sample_o | output | 1 | Input sample enable, second cycle of a cell |
| launch_o | output | 1 | Output launch enable, first cycle of a cell |
| tdm_mode_o | output | 1 | 1 in TDM bus mode, 0 in serial mode |
| bit_o | output | 3 | Bit index within the slot |
| slot_o | output | 5 | Timeslot index |

## Verification
The stuck-pin assertion assumes that the frame pulse pin is high while reset is asserted. Its one-cycle look-back would otherwise see a low level that the reset-held pin register never recorded. The bench therefore holds the pin high through reset. It changes `fp_ni`, `pd_ni` and `sel_i` only on falling clock edges, and it counts pulse spacing in whole cycles, so every falling edge lands on a known count. Every pulse the bench produces is exactly one cycle wide, apart from the deliberate stuck-low run.

// File: rtl/tdm_strobe_pkg.sv
package tdm_strobe_pkg;
  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_TDM    = 1'b1
  } bus_mode_e;

  localparam int unsigned DEF_SLOTS   = 32;
  localparam int unsigned DEF_BITS    = 8;
  localparam int unsigned DEF_TIMEOUT = 1024;
endpackage

// File: rtl/tdm_fp_detect.sv
module tdm_fp_detect
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned FRAME_CLKS = 512,
  parameter int unsigned TIMEOUT    = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fp_ni,
  output logic fall_o,
  output logic stuck_o,
  output logic tdm_o
);
  localparam int unsigned GAP_W = $clog2(TIMEOUT);

  logic             fp_q;
  logic             stuck_q;
  logic             have_prev_q;
  logic [GAP_W-1:0] gap_q;
  bus_mode_e        mode_q;
  logic             spaced;
  logic             timed_out;

  assign fall_o    = fp_q & ~fp_ni;
  assign spaced    = have_prev_q && (gap_q == GAP_W'(FRAME_CLKS - 1));
  assign timed_out = (gap_q == GAP_W'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q        <= 1'b1;
      stuck_q     <= 1'b0;
      have_prev_q <= 1'b0;
      gap_q       <= '0;
      mode_q      <= MODE_SERIAL;
    end else begin
      fp_q    <= fp_ni;
      stuck_q <= ~fp_ni & ~fp_q;
      if (fall_o) begin
        gap_q       <= '0;
        have_prev_q <= 1'b1;
        if (spaced) mode_q <= MODE_TDM;
      end else if (timed_out) begin
        have_prev_q <= 1'b0;
        mode_q      <= MODE_SERIAL;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign stuck_o = stuck_q;
  assign tdm_o   = (mode_q == MODE_TDM);

  // R4: entry only on a falling edge of the pin
  a_r4_entry_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tdm_o) |-> ($past(fp_q) && !$past(fp_ni)));

  // R6: exit only after a full quiet window
  a_r6_exit_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tdm_o) |-> ($past(gap_q) == GAP_W'(TIMEOUT - 1)));
endmodule

// File: rtl/tdm_frame_cnt.sv
module tdm_frame_cnt #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned FRAME_CLKS = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             last;

  assign last = (cnt_q == CNT_W'(FRAME_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (!pd_ni) begin
      run_q <= 1'b0;
    end else if (fall_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  // R11: counters frozen while powered down
  a_r11_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (cnt_q == $past(cnt_q)));

  // R1: a pulse realigns the count
  a_r1_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && fall_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode #(
  parameter int unsigned SLOT_W   = 5,
  parameter int unsigned N_STROBE = 2,
  parameter int unsigned LO_BASE  = 0,
  parameter int unsigned HI_BASE  = 2,
  parameter int unsigned ADPCM_LO = 2,
  parameter int unsigned ADPCM_HI = 3
) (
  input  logic                active_i,
  input  logic                tdm_i,
  input  logic                sel_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                zero_i,
  output logic [N_STROBE-1:0] strobe_o,
  output logic                adpcm_o,
  output logic                frame_o
);
  logic gate;
  assign gate = active_i & tdm_i;

  for (genvar i = 0; i < N_STROBE; i++) begin : g_strobe
    localparam int unsigned SLOT_LO = LO_BASE + i;
    localparam int unsigned SLOT_HI = HI_BASE + i;
    assign strobe_o[i] = gate &&
      (slot_i == (sel_i ? SLOT_W'(SLOT_HI) : SLOT_W'(SLOT_LO)));
  end

  assign adpcm_o = gate &&
    (slot_i == (sel_i ? SLOT_W'(ADPCM_HI) : SLOT_W'(ADPCM_LO)));
  assign frame_o = gate && zero_i;
endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned BITS    = DEF_BITS,
  parameter int unsigned TIMEOUT = DEF_TIMEOUT,
  localparam int unsigned BIT_W  = $clog2(BITS),
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_ni,
  input  logic              pd_ni,
  input  logic              sel_i,
  output logic              bclk_o,
  output logic              en1_o,
  output logic              en2_o,
  output logic              pcm_win_o,
  output logic              adpcm_win_o,
  output logic              frame_o,
  output logic              sample_o,
  output logic              launch_o,
  output logic              tdm_mode_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int unsigned CNT_W      = 1 + BIT_W + SLOT_W;
  localparam int unsigned FRAME_CLKS = 2 * SLOTS * BITS;

  logic             fall;
  logic             stuck;
  logic             tdm;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             active;
  logic             ph;
  logic [1:0]       strobe;

  tdm_fp_detect #(
    .FRAME_CLKS(FRAME_CLKS),
    .TIMEOUT   (TIMEOUT)
  ) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fp_ni  (fp_ni),
    .fall_o (fall),
    .stuck_o(stuck),
    .tdm_o  (tdm)
  );

  tdm_frame_cnt #(
    .CNT_W     (CNT_W),
    .FRAME_CLKS(FRAME_CLKS)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pd_ni (pd_ni),
    .fall_i(fall),
    .cnt_o (cnt),
    .run_o (run)
  );

  assign active = pd_ni & run;
  assign ph     = cnt[0];
  assign bit_o  = cnt[BIT_W:1];
  assign slot_o = cnt[CNT_W-1 -: SLOT_W];

  tdm_slot_decode #(
    .SLOT_W  (SLOT_W),
    .N_STROBE(2),
    .LO_BASE (0),
    .HI_BASE (2),
    .ADPCM_LO(2),
    .ADPCM_HI(3)
  ) u_decode (
    .active_i(active),
    .tdm_i   (tdm),
    .sel_i   (sel_i),
    .slot_i  (slot_o),
    .zero_i  (cnt == '0),
    .strobe_o(strobe),
    .adpcm_o (adpcm_win_o),
    .frame_o (frame_o)
  );

  assign en1_o      = strobe[0];
  assign en2_o      = strobe[1];
  assign pcm_win_o  = |strobe;
  assign bclk_o     = active & ~stuck & ph;
  assign sample_o   = active & ph;
  assign launch_o   = active & ~ph;
  assign tdm_mode_o = tdm;

  // R11: quiet while powered down
  a_r11_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> !(bclk_o || en1_o || en2_o || adpcm_win_o || frame_o || sample_o || launch_o));

  // R7: pin stuck low forces the bit clock low
  a_r7_stuck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fp_ni && $past(!fp_ni)) |=> !bclk_o);

  // R9: the two strobes never overlap
  a_r9_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en1_o, en2_o}));

  // R9: serial mode generates no slot timing
  a_r9_serial_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tdm_mode_o |-> !(en1_o || en2_o || adpcm_win_o || frame_o));

  // R10: ADPCM window stays out of the first slot pair
  a_r10_adpcm_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adpcm_win_o |-> (slot_o >= SLOT_W'(2)));

  // R2: launch is followed by sample
  a_r2_cell_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && pd_ni && !fall) |=> (sample_o || !pd_ni));
endmodule

// File: tb/tb_tdm_strobe_gen.sv
module tb_tdm_strobe_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp_n = 1'b1;
  logic       pd_n = 1'b1;
  logic       sel = 1'b0;
  logic       bclk, en1, en2, pcm_win, adpcm_win, frame, sample, launch, tdm;
  logic [2:0] bit_idx;
  logic [4:0] slot;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tdm_strobe_gen dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fp_ni      (fp_n),
    .pd_ni      (pd_n),
    .sel_i      (sel),
    .bclk_o     (bclk),
    .en1_o      (en1),
    .en2_o      (en2),
    .pcm_win_o  (pcm_win),
    .adpcm_win_o(adpcm_win),
    .frame_o    (frame),
    .sample_o   (sample),
    .launch_o   (launch),
    .tdm_mode_o (tdm),
    .bit_o      (bit_idx),
    .slot_o     (slot)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle low pulse; returns at the negedge where count is 0
  task automatic pulse();
    fp_n = 1'b0;
    @(negedge clk);
    fp_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    #1;
    chk("R12 mode", int'(tdm), 0);
    chk("R12 bit", int'(bit_idx), 0);
    chk("R12 slot", int'(slot), 0);
  endtask

  task automatic t_held_high();
    for (int k = 0; k < 8; k++) begin
      chk("R8 bclk", int'(bclk), k % 2);
      chk("R2 sample", int'(sample), k % 2);
      chk("R2 launch", int'(launch), 1 - (k % 2));
      wait_cyc(1);
    end
  endtask

  task automatic t_serial_and_misspaced();
    pulse();
    chk("R1 bit", int'(bit_idx), 0);
    chk("R1 slot", int'(slot), 0);
    chk("R1 launch", int'(launch), 1);
    chk("R9 serial en1", int'(en1), 0);
    chk("R9 serial frame", int'(frame), 0);
    wait_cyc(519);
    pulse();
    chk("R5 mode stays serial", int'(tdm), 0);
    chk("R5 realign slot", int'(slot), 0);
    chk("R5 realign bit", int'(bit_idx), 0);
  endtask

  task automatic check_slots(input logic s);
    for (int k = 0; k < 64; k++) begin
      int sl = k / 16;
      chk("R1 slot", int'(slot), sl);
      chk("R1 bit", int'(bit_idx), (k / 2) % 8);
      chk("R9 en1", int'(en1), int'(sl == (s ? 2 : 0)));
      chk("R9 en2", int'(en2), int'(sl == (s ? 3 : 1)));
      chk("R9 pcm", int'(pcm_win), int'(sl == (s ? 2 : 0) || sl == (s ? 3 : 1)));
      chk("R10 adpcm", int'(adpcm_win), int'(sl == (s ? 3 : 2)));
      wait_cyc(1);
    end
  endtask

  task automatic t_entry_and_slots();
    wait_cyc(511);
    pulse();
    chk("R4 mode", int'(tdm), 1);
    chk("R3 frame at 0", int'(frame), 1);
    chk("R2 bclk low", int'(bclk), 0);
    wait_cyc(1);
    chk("R3 frame at 1", int'(frame), 0);
    chk("R2 bclk high", int'(bclk), 1);
    chk("R2 sample", int'(sample), 1);
    wait_cyc(511);
    pulse();
    chk("R4 stays", int'(tdm), 1);
    check_slots(1'b0);
    wait_cyc(511 - 64);
    chk("R3 last slot", int'(slot), 31);
    chk("R3 last bit", int'(bit_idx), 7);
    wait_cyc(1);
    chk("R3 wrap slot", int'(slot), 0);
    chk("R3 wrap frame", int'(frame), 1);
    sel = 1'b1;
    #1;
    check_slots(1'b1);
  endtask

  task automatic t_tdm_misspaced_and_timeout();
    pulse();
    chk("R5 tdm kept", int'(tdm), 1);
    chk("R5 tdm realign", int'(slot), 0);
    chk("R5 tdm realign bit", int'(bit_idx), 0);
    wait_cyc(1023);
    chk("R6 before timeout", int'(tdm), 1);
    wait_cyc(1);
    chk("R6 after timeout", int'(tdm), 0);
    chk("R9 serial en", int'(en1 | en2 | adpcm_win), 0);
  endtask

  task automatic t_power_down();
    sel = 1'b0;
    pulse();
    wait_cyc(511);
    pulse();
    chk("R4 reentry", int'(tdm), 1);
    wait_cyc(20);
    pd_n = 1'b0;
    #1;
    chk("R11 quiet", int'({bclk, en1, en2, pcm_win, adpcm_win, frame, sample, launch}), 0);
    chk("R11 slot held", int'(slot), 1);
    chk("R11 bit held", int'(bit_idx), 2);
    wait_cyc(10);
    chk("R11 slot still", int'(slot), 1);
    chk("R11 bit still", int'(bit_idx), 2);
    pd_n = 1'b1;
    #1;
    wait_cyc(5);
    chk("R11 wait quiet", int'({bclk, sample, launch}), 0);
    chk("R11 wait bit", int'(bit_idx), 2);
    pulse();
    chk("R11 restart bit", int'(bit_idx), 0);
    chk("R11 restart slot", int'(slot), 0);
    chk("R11 restart launch", int'(launch), 1);
  endtask

  task automatic t_held_low();
    int ones = 0;
    fp_n = 1'b0;
    wait_cyc(2);
    for (int k = 0; k < 16; k++) begin
      chk("R7 bclk low", int'(bclk), 0);
      ones += int'(sample);
      wait_cyc(1);
    end
    chk("R7 cells still run", ones, 8);
    fp_n = 1'b1;
    wait_cyc(2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_held_high();
    t_serial_and_misspaced();
    t_entry_and_slots();
    t_tdm_misspaced_and_timeout();
    t_power_down();
    t_held_low();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule